// File: doc/BRIEF.md
# PHY Register Access Sequencer

This block lets on-chip logic read and write 16-bit registers inside a PHY that are not mapped into any address space. The only path into the PHY is a narrow side port. The block drives a 32-bit control word on that port and watches a status word that returns an acknowledge flag and 16 bits of read data. Each host request becomes several handshake rounds. In every round the block drives a strobe, waits for the acknowledge to rise, drops the strobe and waits for the acknowledge to fall. Every wait is bounded.

A host presents a request while `busy` is low: a direction bit, a 16-bit register address and, for writes, 16 bits of data. The block always latches the address into the PHY first. A write then latches the data and fires a write strobe. A read fires a read strobe and keeps the 16 bits the PHY returns. When the operation ends, the block raises `done` for one cycle. `error` rises with it if an acknowledge never arrived.

The acknowledge is sampled at a fixed spacing that a prescaler parameter sets in clock cycles. One microsecond is the intended spacing. The number of samples allowed per wait is also a parameter.

Top module: `phy_reg_seq`

## Requirements
- R1: After reset, `phyCtrl` is 0, `busy`, `done` and `error` are 0, and `rdData` is 0.
- R2: The control word carries the payload in bits 15:0. It has a capture-address strobe at bit 16, a capture-data strobe at bit 17, a write strobe at bit 18 and a read strobe at bit 19. Bits 31:20 are always 0 and at most one strobe bit is set at a time.
- R3: Every operation starts with the address phase. The address is driven alone for one cycle, then together with bit 16 until the acknowledge (status bit 16) is seen high, then alone again until the acknowledge is seen low.
- R4: A write continues with the data alone for one cycle, then the data with bit 17 until acknowledge high, then the data alone until acknowledge low. It then drives bit 18 alone until acknowledge high and the data alone until acknowledge low. It finishes by driving 0 in the same cycle as `done`.
- R5: A read continues with bit 19 alone until acknowledge high. At that sample it stores status bits 15:0 in `rdData`. It then drives 0 until acknowledge low and raises `done`.
- R6: During a wait, the acknowledge is sampled every TICK_CYCLES clocks. The first sample comes TICK_CYCLES clocks after the control word changes, and at most MAX_POLLS samples are taken per wait. A level first visible at the last sample still counts as success.
- R7: If the last allowed sample of any wait misses, the next cycle shows `phyCtrl` = 0, `busy` = 0, and `done` and `error` both high.
- R8: A request is taken only while `busy` is low. Requests presented while busy have no effect on the running operation's control words or on the PHY contents.
- R9: `done` is a one-cycle pulse. `error` is high only together with `done`, and it is low after a successful operation.
- R10: `rdData` changes only on a successful read-strobe acknowledge. Writes and failed operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | PHY register address |
| reqData | input | 16 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Acknowledge timeout, valid with `done` |
| rdData | output | 16 | Data from the last successful read |
| phyCtrl | output | 32 | Control word to the PHY side port |
| phyStat | input | 17 | Status from the PHY: read data in 15:0, acknowledge in 16 |

## Verification
Every wait lasts a whole number of sample periods, so completion time is predictable. With TICK_CYCLES = T and an acknowledge that follows within T cycles, `done` is seen 2 + 6T cycles after the accepting edge for a write and 1 + 4T for a read. An acknowledge that needs k samples stretches each wait to kT. A timeout in the first wait is seen 1 + T·MAX_POLLS cycles after acceptance, and a timeout in a later wait adds the preceding waits to that. The bench counts clock edges from the accepting edge and compares the count against these formulas, sampling on the falling edge. It also records every distinct control word and compares the recorded order with the expected round sequence.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  // Sequencer states. The order follows the handshake rounds.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_SET,
    ST_ADR_CAP,
    ST_ADR_REL,
    ST_DAT_SET,
    ST_DAT_CAP,
    ST_DAT_REL,
    ST_WR_ASSERT,
    ST_WR_REL,
    ST_RD_ASSERT,
    ST_RD_REL
  } seqState_e;

  // Which control word the datapath builds next.
  typedef enum logic [2:0] {
    W_ZERO,
    W_ADDR,
    W_ADDR_CAP,
    W_DATA,
    W_DATA_CAP,
    W_WR,
    W_RD
  } wordSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     accept;     // request taken this cycle
    logic     load;       // load a new control word
    wordSel_e sel;        // word to load
    logic     pollStart;  // restart the sample timer
    logic     polling;    // current state waits on the acknowledge
    logic     expAck;     // acknowledge level being waited for
    logic     latchRd;    // keep the read data on a hit
  } seqCtl_t;

endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CTRL_W      = 32,
  parameter int TICK_CYCLES = 50,
  parameter int MAX_POLLS   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W:0]   phyStat,
  output logic [CTRL_W-1:0] phyCtrl,
  output logic [DATA_W-1:0] rdData,
  output logic              ackHit,
  output logic              timeoutNow
);

  // Strobe positions sit directly above the payload field.
  localparam int CAPA_BIT = DATA_W;
  localparam int CAPD_BIT = DATA_W + 1;
  localparam int WR_BIT   = DATA_W + 2;
  localparam int RD_BIT   = DATA_W + 3;
  localparam int ACK_BIT  = DATA_W;
  localparam int POLL_W   = $clog2(MAX_POLLS + 1);

  logic [DATA_W-1:0] addrQ, dataQ, addrSrc;
  logic [CTRL_W-1:0] nextWord;
  logic [POLL_W-1:0] pollCnt;
  logic              tickZero;
  logic              sampleNow;
  logic              ackNow;

  // The address bypasses its register in the accepting cycle.
  always_comb addrSrc = ctl.accept ? reqAddr : addrQ;

  always_comb begin
    nextWord = '0;
    case (ctl.sel)
      W_ADDR:     nextWord[DATA_W-1:0] = addrSrc;
      W_ADDR_CAP: begin
        nextWord[DATA_W-1:0] = addrSrc;
        nextWord[CAPA_BIT]   = 1'b1;
      end
      W_DATA:     nextWord[DATA_W-1:0] = dataQ;
      W_DATA_CAP: begin
        nextWord[DATA_W-1:0] = dataQ;
        nextWord[CAPD_BIT]   = 1'b1;
      end
      W_WR:       nextWord[WR_BIT] = 1'b1;
      W_RD:       nextWord[RD_BIT] = 1'b1;
      default:    nextWord = '0;
    endcase
  end

  // Request capture.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (ctl.accept) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  // Control word register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         phyCtrl <= '0;
    else if (ctl.load) phyCtrl <= nextWord;
  end

  // Sample spacing. A spacing of one cycle needs no counter.
  generate
    if (TICK_CYCLES > 1) begin : g_prescale
      localparam int TICK_W = $clog2(TICK_CYCLES);
      logic [TICK_W-1:0] tickCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        tickCnt <= '0;
        else if (ctl.pollStart)           tickCnt <= TICK_W'(TICK_CYCLES - 1);
        else if (ctl.polling && tickZero) tickCnt <= TICK_W'(TICK_CYCLES - 1);
        else if (ctl.polling)             tickCnt <= tickCnt - 1'b1;
      end
      assign tickZero = (tickCnt == '0);
    end else begin : g_every_cycle
      assign tickZero = 1'b1;
    end
  endgenerate

  // Count of samples taken in the current wait.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        pollCnt <= '0;
    else if (ctl.pollStart)           pollCnt <= '0;
    else if (ctl.polling && tickZero) pollCnt <= pollCnt + 1'b1;
  end

  assign ackNow     = phyStat[ACK_BIT];
  assign sampleNow  = ctl.polling && tickZero;
  assign ackHit     = sampleNow && (ackNow == ctl.expAck);
  assign timeoutNow = sampleNow && (ackNow != ctl.expAck) &&
                      (pollCnt == POLL_W'(MAX_POLLS - 1));

  // Read result.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      rdData <= '0;
    else if (ctl.latchRd && ackHit) rdData <= phyStat[DATA_W-1:0];
  end

  // R2: no more than one strobe, nothing above the strobes.
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phyCtrl[RD_BIT:CAPA_BIT]) && (phyCtrl[CTRL_W-1:RD_BIT+1] == '0));

  // R6: a wait never takes more samples than allowed.
  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.polling |-> (pollCnt < POLL_W'(MAX_POLLS)));

  // R10: the read result moves only while the read strobe is driven.
  p_rd_on_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(phyCtrl[RD_BIT]));

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    ackHit,
  input  logic    timeoutNow,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    error
);

  seqState_e state, nextState;
  logic      writeQ;
  logic      accept, finish, fail;

  function automatic logic isPoll(seqState_e s);
    return s inside {ST_ADR_CAP, ST_ADR_REL, ST_DAT_CAP, ST_DAT_REL,
                     ST_WR_ASSERT, ST_WR_REL, ST_RD_ASSERT, ST_RD_REL};
  endfunction

  function automatic wordSel_e wordFor(seqState_e s);
    case (s)
      ST_ADR_SET, ST_ADR_REL:             return W_ADDR;
      ST_ADR_CAP:                         return W_ADDR_CAP;
      ST_DAT_SET, ST_DAT_REL, ST_WR_REL:  return W_DATA;
      ST_DAT_CAP:                         return W_DATA_CAP;
      ST_WR_ASSERT:                       return W_WR;
      ST_RD_ASSERT:                       return W_RD;
      default:                            return W_ZERO;
    endcase
  endfunction

  always_comb begin
    nextState = state;
    accept    = 1'b0;
    finish    = 1'b0;
    fail      = 1'b0;
    case (state)
      ST_IDLE:      if (reqValid) begin
                      accept    = 1'b1;
                      nextState = ST_ADR_SET;
                    end
      ST_ADR_SET:   nextState = ST_ADR_CAP;
      ST_ADR_CAP:   if (ackHit) nextState = ST_ADR_REL;
      ST_ADR_REL:   if (ackHit) nextState = writeQ ? ST_DAT_SET : ST_RD_ASSERT;
      ST_DAT_SET:   nextState = ST_DAT_CAP;
      ST_DAT_CAP:   if (ackHit) nextState = ST_DAT_REL;
      ST_DAT_REL:   if (ackHit) nextState = ST_WR_ASSERT;
      ST_WR_ASSERT: if (ackHit) nextState = ST_WR_REL;
      ST_WR_REL:    if (ackHit) begin
                      nextState = ST_IDLE;
                      finish    = 1'b1;
                    end
      ST_RD_ASSERT: if (ackHit) nextState = ST_RD_REL;
      ST_RD_REL:    if (ackHit) begin
                      nextState = ST_IDLE;
                      finish    = 1'b1;
                    end
      default:      nextState = ST_IDLE;
    endcase
    if (isPoll(state) && timeoutNow) begin
      nextState = ST_IDLE;
      finish    = 1'b0;
      fail      = 1'b1;
    end
  end

  always_comb begin
    ctl.accept    = accept;
    ctl.load      = (nextState != state);
    ctl.sel       = wordFor(nextState);
    ctl.pollStart = (nextState != state) && isPoll(nextState);
    ctl.polling   = isPoll(state);
    ctl.expAck    = state inside {ST_ADR_CAP, ST_DAT_CAP, ST_WR_ASSERT, ST_RD_ASSERT};
    ctl.latchRd   = (state == ST_RD_ASSERT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      writeQ <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) writeQ <= reqWrite;
      done  <= finish | fail;
      error <= fail;
    end
  end

  assign busy = (state != ST_IDLE);

  // R9: the error flag never appears without done.
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R9: done lasts exactly one cycle.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a missed last sample ends the operation with an error.
  p_timeout_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutNow && isPoll(state)) |=> (!busy && done && error));

  // R8: no request is taken while an operation runs.
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !$past(done)) |-> !accept);

endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CTRL_W      = 32,
  parameter int TICK_CYCLES = 50,
  parameter int MAX_POLLS   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] rdData,
  output logic [CTRL_W-1:0] phyCtrl,
  input  logic [DATA_W:0]   phyStat
);

  seqCtl_t ctl;
  logic    ackHit;
  logic    timeoutNow;

  phy_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .ackHit     (ackHit),
    .timeoutNow (timeoutNow),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  phy_seq_dp #(
    .DATA_W      (DATA_W),
    .CTRL_W      (CTRL_W),
    .TICK_CYCLES (TICK_CYCLES),
    .MAX_POLLS   (MAX_POLLS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .phyStat    (phyStat),
    .phyCtrl    (phyCtrl),
    .rdData     (rdData),
    .ackHit     (ackHit),
    .timeoutNow (timeoutNow)
  );

  // R4 and R7: every operation ends with the control word cleared.
  p_done_word_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (phyCtrl == '0));

endmodule

// File: tb/test_phy_reg_seq.sv
module test_phy_reg_seq;

  localparam int TK = 4;
  localparam int MP = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [15:0] reqAddr, reqData;
  logic        busy, done, error;
  logic [15:0] rdData;
  logic [31:0] phyCtrl;
  logic [16:0] phyStat;

  int nChk  = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  phy_reg_seq #(.TICK_CYCLES(TK), .MAX_POLLS(MP)) i_phy_reg_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .busy(busy), .done(done),
    .error(error), .rdData(rdData), .phyCtrl(phyCtrl), .phyStat(phyStat)
  );

  // PHY model. Mode 0: normal. Mode 1: never raises ack.
  // Mode 2: never drops ack. Mode 3: ignores the read strobe.
  int          rspDly  = 1;
  int          rspMode = 0;
  int          rspCnt  = 0;
  logic        ack     = 1'b0;
  logic [15:0] rspData = '0;
  logic [15:0] capA    = '0;
  logic [15:0] capD    = '0;
  logic [15:0] phyMem [16];

  assign phyStat = {ack, rspData};

  always @(negedge clk) begin
    if (!rstN) begin
      ack    = 1'b0;
      rspCnt = 0;
    end else begin
      logic want, blocked;
      want    = |phyCtrl[19:16];
      blocked = (rspMode == 1 && want && !ack) ||
                (rspMode == 2 && !want && ack) ||
                (rspMode == 3 && phyCtrl[19] && !ack);
      if (want != ack && !blocked) begin
        if (rspCnt + 1 >= rspDly) begin
          ack    = want;
          rspCnt = 0;
          if (want) begin
            if (phyCtrl[16]) capA = phyCtrl[15:0];
            if (phyCtrl[17]) capD = phyCtrl[15:0];
            if (phyCtrl[18]) phyMem[capA[3:0]] = capD;
            if (phyCtrl[19]) rspData = phyMem[capA[3:0]];
          end
        end else begin
          rspCnt++;
        end
      end else begin
        rspCnt = 0;
      end
    end
  end

  // Control word monitor: records each distinct word and format slips.
  logic [31:0] wLog [16];
  int          logN   = 0;
  logic [31:0] lastW  = '0;
  int          fmtBad = 0;

  always @(negedge clk) begin
    if (phyCtrl !== lastW) begin
      if (logN < 16) wLog[logN] = phyCtrl;
      logN++;
      lastW = phyCtrl;
    end
    if (phyCtrl[31:20] != 0 || $countones(phyCtrl[19:16]) > 1) fmtBad++;
  end

  logic [31:0] expSeq [16];
  int          expN;
  int          opCycles;
  logic        opErr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setWrSeq(input logic [15:0] a, input logic [15:0] d);
    expSeq[0] = {16'h0, a};
    expSeq[1] = {16'h1, a};
    expSeq[2] = {16'h0, a};
    expSeq[3] = {16'h0, d};
    expSeq[4] = {16'h2, d};
    expSeq[5] = {16'h0, d};
    expSeq[6] = 32'h0004_0000;
    expSeq[7] = {16'h0, d};
    expSeq[8] = 32'h0;
    expN = 9;
  endtask

  task automatic setRdSeq(input logic [15:0] a);
    expSeq[0] = {16'h0, a};
    expSeq[1] = {16'h1, a};
    expSeq[2] = {16'h0, a};
    expSeq[3] = 32'h0008_0000;
    expSeq[4] = 32'h0;
    expN = 5;
  endtask

  task automatic chkSeq(input string tag);
    int bad = -1;
    if (logN != expN) begin
      chk(1'b0, {tag, " word count"}, logN, expN);
      return;
    end
    for (int i = 0; i < expN; i++) if (bad < 0 && wLog[i] != expSeq[i]) bad = i;
    if (bad >= 0) chk(1'b0, {tag, " word order"}, wLog[bad], expSeq[bad]);
    else          chk(1'b1, tag, 0, 0);
  endtask

  // Runs one request; counts edges from the accepting edge to done.
  task automatic runOp(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input int pokeAt);
    int n;
    @(negedge clk);
    logN     = 0;
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqData  = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == pokeAt) begin
        reqValid = 1'b1;
        reqWrite = !wr;
        reqAddr  = a ^ 16'h000F;
        reqData  = ~d;
      end
      if (n == pokeAt + 3) reqValid = 1'b0;
      if (done || n > 4000) break;
    end
    reqValid = 1'b0;
    opCycles = n;
    opErr    = error;
    @(negedge clk);
  endtask

  task automatic settle();
    rspMode = 0;
    rspDly  = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(phyCtrl == 0, "R1 control word", phyCtrl, 0);
    chk({busy, done, error} == 3'b000, "R1 flags", {busy, done, error}, 0);
    chk(rdData == 0, "R1 read data", rdData, 0);
  endtask

  task automatic t_write_fast();
    rspDly = 1;
    setWrSeq(16'h0003, 16'hBEEF);
    runOp(1'b1, 16'h0003, 16'hBEEF, -1);
    chkSeq("R3 R4 write word sequence");
    chk(opCycles == 2 + 6 * TK, "R6 write latency", opCycles, 2 + 6 * TK);
    chk(opErr == 1'b0, "R9 no error on write", opErr, 0);
    chk(phyMem[3] == 16'hBEEF, "R4 PHY written", phyMem[3], 16'hBEEF);
    chk(phyCtrl == 0 && !busy, "R4 idle after write", phyCtrl, 0);
  endtask

  task automatic t_read_fast();
    rspDly = TK - 1;
    setRdSeq(16'h0003);
    runOp(1'b0, 16'h0003, 16'h0000, -1);
    chkSeq("R3 R5 read word sequence");
    chk(opCycles == 1 + 4 * TK, "R6 read latency", opCycles, 1 + 4 * TK);
    chk(rdData == 16'hBEEF, "R5 read data", rdData, 16'hBEEF);
    chk(opErr == 1'b0, "R9 no error on read", opErr, 0);
  endtask

  task automatic t_slow_ack();
    rspDly = TK + 1;  // two samples per wait
    runOp(1'b1, 16'h0005, 16'h1234, -1);
    chk(opCycles == 2 + 12 * TK, "R6 slow write latency", opCycles, 2 + 12 * TK);
    runOp(1'b0, 16'h0005, 16'h0000, -1);
    chk(opCycles == 1 + 8 * TK, "R6 slow read latency", opCycles, 1 + 8 * TK);
    chk(rdData == 16'h1234, "R5 slow read data", rdData, 16'h1234);
  endtask

  task automatic t_last_sample();
    rspDly = TK * MP;
    runOp(1'b0, 16'h0005, 16'h0000, -1);
    chk(opErr == 1'b0, "R6 last sample accepted", opErr, 0);
    chk(opCycles == 1 + 4 * TK * MP, "R6 last sample latency", opCycles, 1 + 4 * TK * MP);
    settle();
  endtask

  task automatic t_just_late();
    rspDly = TK * MP + 1;
    runOp(1'b0, 16'h0003, 16'h0000, -1);
    chk(opErr == 1'b1, "R7 timeout flagged", opErr, 1);
    chk(opCycles == 1 + TK * MP, "R7 timeout latency", opCycles, 1 + TK * MP);
    chk(phyCtrl == 0 && !busy, "R7 idle after timeout", phyCtrl, 0);
    chk(rdData == 16'h1234, "R10 read data kept on timeout", rdData, 16'h1234);
    settle();
  endtask

  task automatic t_stuck_high();
    rspMode = 2;
    runOp(1'b1, 16'h0006, 16'h7777, -1);
    chk(opErr == 1'b1, "R7 release timeout flagged", opErr, 1);
    chk(opCycles == 1 + TK + TK * MP, "R7 release timeout latency", opCycles,
        1 + TK + TK * MP);
    expSeq[0] = 32'h6; expSeq[1] = 32'h10006; expSeq[2] = 32'h6; expSeq[3] = 0;
    expN = 4;
    chkSeq("R7 words up to timeout");
    chk(phyMem[6] == 16'h0, "R7 no write after timeout", phyMem[6], 0);
    settle();
  endtask

  task automatic t_read_withheld();
    rspMode = 3;
    setRdSeq(16'h0003);
    runOp(1'b0, 16'h0003, 16'h0000, -1);
    chk(opErr == 1'b1, "R7 read strobe timeout", opErr, 1);
    chk(opCycles == 1 + 2 * TK + TK * MP, "R7 read strobe timeout latency",
        opCycles, 1 + 2 * TK + TK * MP);
    chkSeq("R5 R7 read words on timeout");
    chk(rdData == 16'h1234, "R10 read data kept", rdData, 16'h1234);
    settle();
  endtask

  task automatic t_write_keeps_rd();
    runOp(1'b1, 16'h0007, 16'h5A5A, -1);
    chk(opErr == 1'b0 && phyMem[7] == 16'h5A5A, "R4 second write", phyMem[7], 16'h5A5A);
    chk(rdData == 16'h1234, "R10 write leaves read data", rdData, 16'h1234);
  endtask

  task automatic t_busy_ignore();
    setWrSeq(16'h0006, 16'h0F0F);
    runOp(1'b1, 16'h0006, 16'h0F0F, 3);
    chkSeq("R8 busy request ignored");
    chk(opCycles == 2 + 6 * TK, "R8 latency unchanged", opCycles, 2 + 6 * TK);
    chk(phyMem[9] == 16'h0 && phyMem[6] == 16'h0F0F, "R8 PHY contents",
        phyMem[9], 16'h0);
    runOp(1'b0, 16'h0009, 16'h0000, -1);
    chk(rdData == 16'h0000, "R8 untouched register reads zero", rdData, 0);
  endtask

  task automatic t_all_ones();
    setWrSeq(16'h000F, 16'hFFFF);
    runOp(1'b1, 16'h000F, 16'hFFFF, -1);
    chkSeq("R2 R4 all-ones write words");
    runOp(1'b0, 16'h000F, 16'h0000, -1);
    chk(rdData == 16'hFFFF, "R5 all-ones read", rdData, 16'hFFFF);
    chk(fmtBad == 0, "R2 control word format", fmtBad, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) phyMem[i] = '0;
    rstN     = 1'b0;
    reqValid = 1'b0;
    reqWrite = 1'b0;
    reqAddr  = '0;
    reqData  = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_fast();
    t_read_fast();
    t_slow_ack();
    t_last_sample();
    t_just_late();
    t_stuck_high();
    t_read_withheld();
    t_write_keeps_rd();
    t_busy_ignore();
    t_all_ones();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog R9: actual no completion expected done pulse");
    summary();
    $finish;
  end

endmodule